// File: doc/BRIEF.md
# Execution Stratum Termination Controller

This per-core controller slices a thread's execution into global strata so that a multithreaded run can be made repeatable. A stratum opens with an execute phase. In that phase the core issues instructions and the controller counts events toward a threshold. The stratum then closes and a publish phase follows, in which buffered stores drain to memory. Last comes a barrier that every core must reach before any core may begin the next stratum.

The mode is chosen per stratum. In the two instruction-counting modes the close depends only on architectural events, so the run can be repeated. In the cycle-counting mode the close follows elapsed time, which gives better load balance. All three modes close on a synchronization event. Only the bounded mode also closes when the write buffer is exhausted. An atomic read-modify-write always closes the stratum. It is performed after the publish drain as the core's final store, and the next instruction waits for the following stratum. Interrupts are held back and reported only at a stratum boundary.

The instruction pipeline, the write-buffer drain and the barrier network lie outside this block. Each of them is reached through a single-wire handshake.

Top module: `strat_ctrl`

## Requirements
- R1: While reset is held and directly after it, the core is waiting at the barrier: bar_req_o=1, and issue_en_o, publish_o, end_o, atomic_go_o and irq_take_o are all 0. Each stratum begins in the cycle after the one in which bar_rel_i is sampled high while bar_req_o=1. From that cycle issue_en_o=1.
- R2: In mode code 0 (and code 3, which behaves the same), the execute phase ends in the cycle where the limit-th retire_i pulse of the stratum is sampled. That pulse is counted.
- R3: In mode code 1, the execute phase lasts exactly limit cycles whatever retire_i does.
- R4: A sync_i pulse in any execute cycle ends the stratum in that cycle, with cause code 1.
- R5: In mode code 2, wbuf_full_i ends the stratum in the cycle it is sampled, with cause code 2. In modes 0, 1 and 3 it has no effect.
- R6: atomic_i ends the stratum in its cycle, with cause code 3. In that stratum atomic_go_o pulses exactly once, for one cycle, after publish_o falls and before bar_req_o rises. In any other stratum it never pulses.
- R7: When several causes occur in the same cycle, the reported cause follows this priority: atomic (3), then sync (1), then write-buffer exhaustion (2), then threshold (0).
- R8: end_o is a one-cycle pulse in the first publish cycle. cause_o is valid in that same cycle.
- R9: publish_o stays high until flush_done_i is sampled high. bar_req_o then stays high until bar_rel_i is sampled high.
- R10: mode_i and limit_i are sampled only at a stratum start, and the event count restarts from zero. Changing either input during a stratum has no effect on that stratum.
- R11: If irq_i is high when the barrier is released, irq_take_o pulses in the first execute cycle of the new stratum. At all other times it stays 0.
- R12: A limit of 0 behaves like a limit of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Mode: 0 instruction count, 1 cycle count, 2 bounded instruction count, 3 as 0 |
| limit_i | input | CNT_W | Stratum threshold, sampled at stratum start |
| retire_i | input | 1 | One instruction retired this cycle |
| sync_i | input | 1 | Synchronization event |
| wbuf_full_i | input | 1 | Write buffer out of entries |
| atomic_i | input | 1 | Atomic read-modify-write reached issue |
| flush_done_i | input | 1 | Publish drain complete |
| bar_rel_i | input | 1 | Global barrier release |
| irq_i | input | 1 | Pending external interrupt |
| issue_en_o | output | 1 | Execute phase, issue allowed |
| publish_o | output | 1 | Publish phase active |
| atomic_go_o | output | 1 | Perform the held atomic now |
| bar_req_o | output | 1 | Waiting at the global barrier |
| end_o | output | 1 | Stratum-end pulse |
| cause_o | output | 2 | End cause: 0 threshold, 1 sync, 2 write buffer, 3 atomic |
| irq_take_o | output | 1 | Deliver the interrupt at this boundary |

## Verification
The count is per stratum, so an error in the counter or in the latched limit shows up as an execute phase of the wrong length. That is visible at end_o within the same stratum. A wrong cause choice or a wrong mode gate for write-buffer exhaustion appears on cause_o in the first publish cycle. If the atomic-pending flag sticks or gets lost, atomic_go_o misbehaves between the fall of publish_o and the rise of bar_req_o. Interrupt timing errors show up on irq_take_o in the first execute cycle, or as a pulse in any other cycle.

// File: rtl/strat_pkg.sv
package strat_pkg;

  typedef enum logic [1:0] {
    MD_INSTR     = 2'd0,
    MD_CYCLE     = 2'd1,
    MD_BOUNDED   = 2'd2,
    MD_INSTR_ALT = 2'd3
  } strat_mode_e;

  typedef enum logic [1:0] {
    CZ_LIMIT  = 2'd0,
    CZ_SYNC   = 2'd1,
    CZ_WBUF   = 2'd2,
    CZ_ATOMIC = 2'd3
  } strat_cause_e;

  typedef enum logic [1:0] {
    ST_EXEC    = 2'd0,
    ST_PUBLISH = 2'd1,
    ST_ATOMIC  = 2'd2,
    ST_BARRIER = 2'd3
  } strat_state_e;

  // Cycle mode counts every execute cycle; the others count retirements.
  function automatic logic counts_cycles(input strat_mode_e m);
    return m == MD_CYCLE;
  endfunction

  // Only the bounded mode closes on write-buffer exhaustion.
  function automatic logic wbuf_closes(input strat_mode_e m);
    return m == MD_BOUNDED;
  endfunction

  // Cause priority: atomic, sync, write buffer, threshold.
  function automatic strat_cause_e pick_cause(input logic atom, input logic syn,
                                              input logic wbf);
    if (atom)     return CZ_ATOMIC;
    else if (syn) return CZ_SYNC;
    else if (wbf) return CZ_WBUF;
    else          return CZ_LIMIT;
  endfunction

endpackage

// File: rtl/strat_count.sv
module strat_count
  import strat_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] limit_i,
  input  strat_mode_e      mode_i,
  input  logic             active_i,
  input  logic             retire_i,
  output strat_mode_e      mode_q_o,
  output logic             hit_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  strat_mode_e      mode_q;
  logic             event_w;

  // True when one more event brings the count to the limit (limit 0 acts as 1).
  function automatic logic reached(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] l);
    return ({1'b0, c} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, l};
  endfunction

  assign event_w  = active_i && (counts_cycles(mode_q) || retire_i);
  assign hit_o    = event_w && reached(cnt_q, lim_q);
  assign mode_q_o = mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lim_q  <= '0;
      mode_q <= MD_INSTR;
    end else if (start_i) begin
      cnt_q  <= '0;
      lim_q  <= limit_i;
      mode_q <= mode_i;
    end else if (event_w && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R10: the sampled limit and mode only move at a stratum start
  assert_limit_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(lim_q) && $stable(mode_q)));

  // R10: the count is frozen outside the execute phase
  assert_count_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_i && !start_i) |=> $stable(cnt_q));

endmodule

// File: rtl/strat_cause.sv
module strat_cause
  import strat_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  strat_mode_e  mode_i,
  input  logic         active_i,
  input  logic         hit_i,
  input  logic         sync_i,
  input  logic         wbuf_full_i,
  input  logic         atomic_i,
  output logic         end_o,
  output strat_cause_e cause_o
);

  logic wbuf_eff;

  assign wbuf_eff = active_i && wbuf_full_i && wbuf_closes(mode_i);
  assign end_o    = active_i && (hit_i || sync_i || atomic_i || wbuf_eff);
  assign cause_o  = pick_cause(atomic_i, sync_i, wbuf_eff);

  // R5: a write-buffer close never appears outside the bounded mode
  assert_wbuf_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (end_o && cause_o == CZ_WBUF) |-> (mode_i == MD_BOUNDED));

  // R7: an atomic in an execute cycle always wins
  assert_atomic_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && atomic_i) |-> (end_o && cause_o == CZ_ATOMIC));

endmodule

// File: rtl/strat_fsm.sv
module strat_fsm
  import strat_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         end_i,
  input  strat_cause_e cause_i,
  input  logic         flush_done_i,
  input  logic         bar_rel_i,
  input  logic         irq_i,
  output logic         start_o,
  output logic         active_o,
  output logic         issue_en_o,
  output logic         publish_o,
  output logic         atomic_go_o,
  output logic         bar_req_o,
  output logic         end_o,
  output logic [1:0]   cause_o,
  output logic         irq_take_o
);

  strat_state_e state_q, state_d;
  logic         atom_pend_q;
  logic         atom_done_q;
  logic         end_q;
  strat_cause_e cause_q;
  logic         irq_q;

  assign active_o    = state_q == ST_EXEC;
  assign issue_en_o  = active_o;
  assign publish_o   = state_q == ST_PUBLISH;
  assign atomic_go_o = state_q == ST_ATOMIC;
  assign bar_req_o   = state_q == ST_BARRIER;
  assign start_o     = bar_req_o && bar_rel_i;
  assign end_o       = end_q;
  assign cause_o     = cause_q;
  assign irq_take_o  = irq_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_EXEC:    if (end_i) state_d = ST_PUBLISH;
      ST_PUBLISH: if (flush_done_i) state_d = atom_pend_q ? ST_ATOMIC : ST_BARRIER;
      ST_ATOMIC:  state_d = ST_BARRIER;
      ST_BARRIER: if (bar_rel_i) state_d = ST_EXEC;
      default:    state_d = ST_BARRIER;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_BARRIER;
      atom_pend_q <= 1'b0;
      atom_done_q <= 1'b0;
      end_q       <= 1'b0;
      cause_q     <= CZ_LIMIT;
      irq_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      end_q   <= active_o && end_i;
      irq_q   <= start_o && irq_i;
      if (active_o && end_i) begin
        cause_q     <= cause_i;
        atom_pend_q <= cause_i == CZ_ATOMIC;
      end else if (atomic_go_o) begin
        atom_pend_q <= 1'b0;
      end
      if (start_o)          atom_done_q <= 1'b0;
      else if (atomic_go_o) atom_done_q <= 1'b1;
    end
  end

  // R8: the end marker is a single pulse in the first publish cycle
  assert_end_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |=> !end_o);
  assert_end_in_publish_R8: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |-> publish_o);

  // R6: at most one atomic per stratum
  assert_one_atomic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    atomic_go_o |-> !atom_done_q);
  assert_atomic_after_publish_R6: assert property (@(posedge clk) disable iff (!rst_n)
    atomic_go_o |-> ($past(publish_o) && $past(flush_done_i)));

  // R9: publish and barrier wait for their handshakes
  assert_publish_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (publish_o && !flush_done_i) |=> publish_o);
  assert_barrier_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_req_o && !bar_rel_i) |=> bar_req_o);

  // R11: interrupts are handed over only right after a barrier release
  assert_irq_boundary_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take_o |-> ($past(bar_req_o && bar_rel_i) && issue_en_o));

endmodule

// File: rtl/strat_ctrl.sv
module strat_ctrl
  import strat_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             retire_i,
  input  logic             sync_i,
  input  logic             wbuf_full_i,
  input  logic             atomic_i,
  input  logic             flush_done_i,
  input  logic             bar_rel_i,
  input  logic             irq_i,
  output logic             issue_en_o,
  output logic             publish_o,
  output logic             atomic_go_o,
  output logic             bar_req_o,
  output logic             end_o,
  output logic [1:0]       cause_o,
  output logic             irq_take_o
);

  // Internal events, named for assertions and debug
  logic         ev_start;
  logic         ev_active;
  logic         ev_hit;
  logic         ev_end;
  strat_cause_e ev_cause;
  strat_mode_e  ev_mode;

  strat_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (ev_start),
    .limit_i  (limit_i),
    .mode_i   (strat_mode_e'(mode_i)),
    .active_i (ev_active),
    .retire_i (retire_i),
    .mode_q_o (ev_mode),
    .hit_o    (ev_hit)
  );

  strat_cause u_cause (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (ev_mode),
    .active_i    (ev_active),
    .hit_i       (ev_hit),
    .sync_i      (sync_i),
    .wbuf_full_i (wbuf_full_i),
    .atomic_i    (atomic_i),
    .end_o       (ev_end),
    .cause_o     (ev_cause)
  );

  strat_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .end_i        (ev_end),
    .cause_i      (ev_cause),
    .flush_done_i (flush_done_i),
    .bar_rel_i    (bar_rel_i),
    .irq_i        (irq_i),
    .start_o      (ev_start),
    .active_o     (ev_active),
    .issue_en_o   (issue_en_o),
    .publish_o    (publish_o),
    .atomic_go_o  (atomic_go_o),
    .bar_req_o    (bar_req_o),
    .end_o        (end_o),
    .cause_o      (cause_o),
    .irq_take_o   (irq_take_o)
  );

  // R2: a threshold close only comes from a counted event
  assert_hit_needs_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |-> ev_active);

  // R1: a new stratum only opens from the barrier
  assert_start_from_barrier_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(issue_en_o) |-> $past(bar_req_o && bar_rel_i));

endmodule

// File: tb/strat_ctrl_tb.sv
module strat_ctrl_tb_top;

  localparam int CNT_W   = 16;
  localparam int BAR_LAT = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       mode_i = 2'd0;
  logic [CNT_W-1:0] limit_i = '0;
  logic             retire_i = 1'b0;
  logic             sync_i = 1'b0;
  logic             wbuf_full_i = 1'b0;
  logic             atomic_i = 1'b0;
  logic             flush_done_i = 1'b0;
  logic             bar_rel_i = 1'b0;
  logic             irq_i = 1'b0;
  logic             issue_en_o, publish_o, atomic_go_o, bar_req_o, end_o, irq_take_o;
  logic [1:0]       cause_o;

  int checks = 0;
  int errors = 0;
  int exp_len_q[$];
  int exp_cause_q[$];

  always #5 clk = ~clk;

  strat_ctrl #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .limit_i(limit_i),
    .retire_i(retire_i), .sync_i(sync_i), .wbuf_full_i(wbuf_full_i),
    .atomic_i(atomic_i), .flush_done_i(flush_done_i), .bar_rel_i(bar_rel_i),
    .irq_i(irq_i), .issue_en_o(issue_en_o), .publish_o(publish_o),
    .atomic_go_o(atomic_go_o), .bar_req_o(bar_req_o), .end_o(end_o),
    .cause_o(cause_o), .irq_take_o(irq_take_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Fabric model: drain takes two cycles, barrier releases after BAR_LAT cycles
  int pub_cnt = 0;
  int bar_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      pub_cnt = publish_o ? pub_cnt + 1 : 0;
      flush_done_i = pub_cnt >= 2;
      bar_cnt = bar_req_o ? bar_cnt + 1 : 0;
      bar_rel_i = bar_cnt >= BAR_LAT;
    end
  end

  // Monitor: pops expected items on each end pulse
  int  exec_len = 0;
  int  pub_len = 0;
  int  atom_cnt = 0;
  int  last_cause = 0;
  bit  prev_end = 0;
  bit  prev_bar = 1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (issue_en_o) exec_len++;
      if (publish_o) pub_len++;
      if (atomic_go_o) begin
        atom_cnt++;
        check(!publish_o && !issue_en_o && !bar_req_o, "R6 atomic slot", 1, 0);
      end
      if (prev_end) check(!end_o, "R8 end pulse width", end_o, 0);
      if (end_o) begin
        check(publish_o, "R8 end in publish", publish_o, 1);
        if (exp_len_q.size() == 0) begin
          check(0, "R8 unexpected end", 1, 0);
        end else begin
          int el, ec;
          el = exp_len_q.pop_front();
          ec = exp_cause_q.pop_front();
          check(exec_len == el, "R2/R3/R10/R12 exec length", exec_len, el);
          check(int'(cause_o) == ec, "R4/R5/R6/R7 cause", cause_o, ec);
          last_cause = int'(cause_o);
        end
        exec_len = 0;
      end
      if (bar_req_o && !prev_bar) begin
        check(pub_len == 2, "R9 publish length", pub_len, 2);
        check(atom_cnt == (last_cause == 3 ? 1 : 0), "R6 atomic count", atom_cnt,
              last_cause == 3 ? 1 : 0);
        pub_len = 0;
        atom_cnt = 0;
      end
      prev_end = end_o;
      prev_bar = bar_req_o;
    end
  end

  // Independent model of the requirements
  function automatic void predict(input int md, input int lim, input int per,
                                  input int sy_at, input int wf_at, input int at_at,
                                  output int len, output int cause);
    int eff, cnt;
    bit ev, th, wf;
    eff = (lim == 0) ? 1 : lim;
    cnt = 0;
    len = -1;
    cause = -1;
    for (int c = 0; c < 1000; c++) begin
      ev = (md == 1) ? 1'b1 : (per != 0 && (c % per) == 0);
      th = ev && (cnt + 1 >= eff);
      wf = (c == wf_at) && (md == 2);
      if (c == at_at || c == sy_at || wf || th) begin
        len = c + 1;
        cause = (c == at_at) ? 3 : (c == sy_at) ? 1 : wf ? 2 : 0;
        return;
      end
      if (ev) cnt++;
    end
  endfunction

  bit irq_pending = 0;

  task automatic run_strat(input int md, input int lim, input int per, input int sy_at,
                           input int wf_at, input int at_at, input bit raise_irq);
    int el, ec, c;
    while (!bar_req_o) @(negedge clk);
    mode_i  = md[1:0];
    limit_i = lim[CNT_W-1:0];
    predict(md, lim, per, sy_at, wf_at, at_at, el, ec);
    exp_len_q.push_back(el);
    exp_cause_q.push_back(ec);
    while (!issue_en_o) @(negedge clk);
    // R11: interrupt handed over in the first execute cycle only if pending
    check(irq_take_o == irq_pending, "R11 irq at boundary", irq_take_o, irq_pending);
    irq_i = 1'b0;
    irq_pending = 0;
    // R10: mid-stratum changes must be ignored
    limit_i = 1;
    mode_i  = 2'd1;
    c = 0;
    while (issue_en_o) begin
      retire_i    = per != 0 && (c % per) == 0;
      sync_i      = c == sy_at;
      wbuf_full_i = c == wf_at;
      atomic_i    = c == at_at;
      if (raise_irq) irq_i = 1'b1;
      if (c > 0) check(!irq_take_o, "R11 no irq mid stratum", irq_take_o, 0);
      @(negedge clk);
      c++;
    end
    retire_i = 0; sync_i = 0; wbuf_full_i = 0; atomic_i = 0;
    if (raise_irq) irq_pending = 1;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(bar_req_o == 1, "R1 bar_req in reset", bar_req_o, 1);
    check(!issue_en_o && !publish_o, "R1 phases idle", issue_en_o, 0);
    check(!end_o && !atomic_go_o && !irq_take_o, "R1 pulses idle", end_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bar_req_o == 1 && !issue_en_o, "R1 waits for release", issue_en_o, 0);

    run_strat(1, 5, 0, -1, -1, -1, 0);   // R3 cycle count
    run_strat(0, 3, 2, -1, -1, -1, 0);   // R2 sparse retires, R10
    run_strat(0, 0, 1, -1, -1, -1, 0);   // R12 limit zero
    run_strat(1, 10, 0, 3, -1, -1, 0);   // R4 sync in cycle mode
    run_strat(2, 20, 1, -1, 2, -1, 0);   // R5 bounded overflow
    run_strat(0, 4, 1, -1, 1, -1, 0);    // R5 overflow ignored in mode 0
    run_strat(1, 6, 0, -1, 2, -1, 0);    // R5 overflow ignored in mode 1
    run_strat(0, 50, 3, -1, -1, 4, 1);   // R6 atomic, R11 irq raised
    run_strat(2, 2, 1, 1, 1, 1, 0);      // R7 all at once, atomic wins
    run_strat(2, 9, 1, 2, 2, -1, 0);     // R7 sync over overflow
    run_strat(2, 3, 1, -1, 2, -1, 0);    // R7 overflow over threshold
    run_strat(3, 2, 1, -1, -1, -1, 0);   // R2 mode 3 as mode 0
    run_strat(1, 1, 0, 5, -1, -1, 0);    // R3 single-cycle stratum
    while (!bar_req_o) @(negedge clk);
    repeat (2) @(negedge clk);
    check(exp_len_q.size() == 0, "R8 all ends seen", exp_len_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule